// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Engine

This block is the device end of a three-wire serial EEPROM link. A host drives chip select, a shift clock and a serial data line. The block returns data on a single output that it drives only when it has something to say. Behind the serial front end sits a byte array, 2048 bytes by default, that a static strap presents either as byte-wide locations or as 16-bit words. Each instruction is a start bit, a two-bit opcode and an address field, optionally followed by a data word. The block supports single-location read, write and erase, whole-array fill and erase, and two commands that arm and disarm programming.

The shift clock and data line are sampled by a fast system clock through two-flop synchronisers, and the shift clock's rising edges are found by edge detection. Programming is modelled as a self-timed cycle of `PROG_CYCLES` system clocks. A host that deselects the block and selects it again during that cycle reads a ready/busy flag on the data output. Whole-array operations sweep the storage at one byte per clock inside the busy window.

Top module: `seeprom_slave`

## Requirements
- R1: An instruction begins with the first data-line 1 sampled on a shift-clock rise while selected; 0 bits before it are skipped. Two opcode bits follow, then an address of `ADDR_W8` bits in byte mode or `ADDR_W8-1` bits in word mode, MSB first.
- R2: The strap selects the organisation at each start bit: high for 16-bit words, low for bytes. Word `w` occupies byte `2w` (upper half) and byte `2w+1` (lower half).
- R3: Opcode 10 reads. After the last address bit, the output first carries one 0 and then the word MSB first. The output moves only on shift-clock rises.
- R4: While select stays high, a read goes on with the next location and no 0 between words, wrapping from the top location to location 0.
- R5: A programming-enable latch is clear after reset. Opcode 00 with top address bits 11 sets it, and with 00 clears it. While it is clear, opcodes 01 and 11 and the bulk sub-codes change nothing and start no busy cycle. Reads work in either state.
- R6: Opcode 01 followed by a data word of the current width stores that word at the address.
- R7: Opcode 11 sets every bit of the addressed location to 1. Opcode 00 with top address bits 10 sets every bit of the array to 1.
- R8: Opcode 00 with top address bits 01, followed by a data word, writes that word to every location.
- R9: Programming starts after the last data bit (01, bulk fill) or the last address bit (11, bulk erase). If select is then low for at least `CS_LOW_MIN` synchronised clocks and rises while busy, the output drives 0 until the cycle ends and 1 afterwards. A shorter low pulse gives no status.
- R10: If select rises only after the programming cycle has ended, the output stays undriven.
- R11: A start bit received while busy makes the rest of that selection be ignored, so it changes no memory.
- R12: Dropping select before an instruction is complete abandons it: memory is unchanged and no busy cycle starts.
- R13: The output enable is low while select is low, and also while selected outside a read or a status report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial shift clock |
| diIn | input | 1 | Serial data from the host |
| orgWide | input | 1 | Organisation strap: 1 selects 16-bit words, 0 bytes |
| doOut | output | 1 | Serial data to the host |
| doOe | output | 1 | Output enable for doOut |

## Verification
The hardest state to reach is a status report that overlaps a second instruction. The bench finishes a write, drops select for the minimum time and raises it again. It then clocks a complete write command in while the busy window is still open and watches the flag turn from 0 to 1. A read-back afterwards shows that the second location kept its old value. Two neighbours of that case are the short deselect pulse and the deselect that outlasts the programming cycle. Both are timed in system clocks from the bench's known `PROG_CYCLES` and `CS_LOW_MIN`. The whole array is written and read back in both organisations, so the wrap of the sequential read and the byte placement of words are covered.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

  typedef enum logic [1:0] {
    PROG_WRITE = 2'd0,
    PROG_ERASE = 2'd1,
    PROG_FILL  = 2'd2,
    PROG_CLEAR = 2'd3
  } progOp_e;

  typedef struct packed {
    logic    progStart;
    progOp_e op;
    logic    wide;
  } progStrobe_t;

endpackage

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/seeprom_store.sv
module seeprom_store
  import seeprom_pkg::*;
#(
  parameter int ADDR_W8     = 11,
  parameter int PROG_CYCLES = 500000
) (
  input  logic               clk,
  input  logic               rstN,
  input  progStrobe_t        strb,
  input  logic [ADDR_W8-1:0] progAddr,
  input  logic [15:0]        progData,
  input  logic [ADDR_W8-1:0] rdAddr,
  input  logic               rdWide,
  output logic [15:0]        rdWord,
  output logic               busy
);

  localparam int DEPTH = 1 << ADDR_W8;
  localparam int AW16  = ADDR_W8 - 1;
  localparam int PCW   = $clog2(PROG_CYCLES + 1);

  logic [7:0]         mem [DEPTH];
  logic [PCW-1:0]     progCnt;
  logic               sweepOn;
  logic [ADDR_W8-1:0] sweepIdx;
  logic [15:0]        sweepWord;
  logic               sweepWide;

  logic               wrEnA, wrEnB;
  logic [ADDR_W8-1:0] wrAddrA, wrAddrB;
  logic [7:0]         wrByteA, wrByteB;
  logic [15:0]        singleWord;
  logic               singleOp, bulkOp;

  assign singleOp   = (strb.op == PROG_WRITE) || (strb.op == PROG_ERASE);
  assign bulkOp     = !singleOp;
  assign singleWord = (strb.op == PROG_ERASE) ? 16'hFFFF : progData;

  // write ports: the sweep owns port A; a single write may use both ports
  always_comb begin
    wrEnA   = 1'b0;
    wrEnB   = 1'b0;
    wrAddrA = '0;
    wrAddrB = '0;
    wrByteA = '0;
    wrByteB = '0;
    if (sweepOn) begin
      wrEnA   = 1'b1;
      wrAddrA = sweepIdx;
      wrByteA = (sweepWide && !sweepIdx[0]) ? sweepWord[15:8] : sweepWord[7:0];
    end else if (strb.progStart && singleOp) begin
      wrEnA = 1'b1;
      if (strb.wide) begin
        wrEnB   = 1'b1;
        wrAddrA = {progAddr[AW16-1:0], 1'b0};
        wrAddrB = {progAddr[AW16-1:0], 1'b1};
        wrByteA = singleWord[15:8];
        wrByteB = singleWord[7:0];
      end else begin
        wrAddrA = progAddr;
        wrByteA = singleWord[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrEnA) mem[wrAddrA] <= wrByteA;
    if (wrEnB) mem[wrAddrB] <= wrByteB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progCnt   <= '0;
      sweepOn   <= 1'b0;
      sweepIdx  <= '0;
      sweepWord <= '0;
      sweepWide <= 1'b0;
    end else if (strb.progStart) begin
      progCnt <= PCW'(PROG_CYCLES);
      if (bulkOp) begin
        sweepOn   <= 1'b1;
        sweepIdx  <= '0;
        sweepWord <= (strb.op == PROG_CLEAR) ? 16'hFFFF : progData;
        sweepWide <= strb.wide;
      end
    end else begin
      if (progCnt != '0) progCnt <= progCnt - PCW'(1);
      if (sweepOn) begin
        sweepIdx <= sweepIdx + ADDR_W8'(1);
        if (&sweepIdx) sweepOn <= 1'b0;
      end
    end
  end

  assign busy = (progCnt != '0) || sweepOn;

  assign rdWord = rdWide ? {mem[{rdAddr[AW16-1:0], 1'b0}], mem[{rdAddr[AW16-1:0], 1'b1}]}
                         : {8'h00, mem[rdAddr]};

  // R11: the control side never launches programming into a running cycle
  assert_no_start_while_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.progStart |-> !busy);

  // R9: every busy window is opened by a start strobe
  assert_busy_follows_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.progStart));

  // R9: a start strobe always yields a busy cycle
  assert_start_makes_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.progStart |=> busy);

endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
  import seeprom_pkg::*;
#(
  parameter int ADDR_W8    = 11,
  parameter int CS_LOW_MIN = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csS,
  input  logic               skS,
  input  logic               diS,
  input  logic               orgWide,
  input  logic               busy,
  input  logic [15:0]        rdWord,
  output progStrobe_t        strb,
  output logic [ADDR_W8-1:0] progAddr,
  output logic [15:0]        progData,
  output logic [ADDR_W8-1:0] rdAddr,
  output logic               rdWide,
  output logic               doOut,
  output logic               doOe
);

  localparam int AW16   = ADDR_W8 - 1;
  localparam int HW     = ADDR_W8 + 2;
  localparam int CNT_W  = $clog2(HW + 17);
  localparam int LOWC_W = $clog2(CS_LOW_MIN + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_SKIP} state_e;

  state_e             state;
  logic               skQ, csQ;
  logic [HW-2:0]      hdrShift;
  logic [14:0]        dataShift;
  logic [CNT_W-1:0]   bitCnt;
  logic               wideQ, welQ;
  progOp_e            pendOp;
  logic [ADDR_W8-1:0] rdPtr;
  logic [15:0]        outShift;
  logic [4:0]         outRemain;
  logic               doBitQ;
  logic               statusArm, statusMode;
  logic [LOWC_W-1:0]  csLowCnt;
  progStrobe_t        strbQ;
  logic [ADDR_W8-1:0] progAddrQ;
  logic [15:0]        progDataQ;

  logic               skRise, csRise;
  logic [HW-1:0]      hdrNext;
  logic [15:0]        dataNext;
  logic [CNT_W-1:0]   bitNext, hdrLen, wordLen;
  logic [1:0]         opc, sub;
  logic [ADDR_W8-1:0] addrDec, ptrMask;
  logic [15:0]        loadWord;

  assign skRise   = skS & ~skQ;
  assign csRise   = csS & ~csQ;
  assign hdrNext  = {hdrShift, diS};
  assign dataNext = {dataShift, diS};
  assign bitNext  = bitCnt + CNT_W'(1);
  assign hdrLen   = wideQ ? CNT_W'(HW - 1) : CNT_W'(HW);
  assign wordLen  = wideQ ? CNT_W'(16) : CNT_W'(8);
  assign opc      = wideQ ? hdrNext[AW16+1:AW16] : hdrNext[ADDR_W8+1:ADDR_W8];
  assign sub      = wideQ ? hdrNext[AW16-1 -: 2] : hdrNext[ADDR_W8-1 -: 2];
  assign addrDec  = wideQ ? {1'b0, hdrNext[AW16-1:0]} : hdrNext[ADDR_W8-1:0];
  assign ptrMask  = wideQ ? {1'b0, {AW16{1'b1}}} : {ADDR_W8{1'b1}};
  assign loadWord = wideQ ? rdWord : {rdWord[7:0], 8'h00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      skQ        <= 1'b0;
      csQ        <= 1'b0;
      hdrShift   <= '0;
      dataShift  <= '0;
      bitCnt     <= '0;
      wideQ      <= 1'b0;
      welQ       <= 1'b0;
      pendOp     <= PROG_WRITE;
      rdPtr      <= '0;
      outShift   <= '0;
      outRemain  <= '0;
      doBitQ     <= 1'b0;
      statusArm  <= 1'b0;
      statusMode <= 1'b0;
      csLowCnt   <= '0;
      strbQ      <= '0;
      progAddrQ  <= '0;
      progDataQ  <= '0;
    end else begin
      skQ             <= skS;
      csQ             <= csS;
      strbQ.progStart <= 1'b0;
      if (strbQ.progStart) statusArm <= 1'b1;

      if (!csS) begin
        // deselected: abandon whatever was in flight
        state      <= ST_IDLE;
        statusMode <= 1'b0;
        if (csLowCnt != LOWC_W'(CS_LOW_MIN)) csLowCnt <= csLowCnt + LOWC_W'(1);
        if (!busy) statusArm <= 1'b0;
      end else begin
        csLowCnt <= '0;
        if (csRise && statusArm && (csLowCnt == LOWC_W'(CS_LOW_MIN))) statusMode <= 1'b1;

        if (skRise) begin
          unique case (state)
            ST_IDLE: begin
              if (diS) begin
                if (busy) begin
                  state <= ST_SKIP;
                end else begin
                  state      <= ST_HDR;
                  bitCnt     <= '0;
                  hdrShift   <= '0;
                  wideQ      <= orgWide;
                  statusMode <= 1'b0;
                end
              end
            end

            ST_HDR: begin
              hdrShift <= hdrNext[HW-2:0];
              bitCnt   <= bitNext;
              if (bitNext == hdrLen) begin
                state <= ST_SKIP;
                unique case (opc)
                  2'b10: begin
                    state     <= ST_READ;
                    rdPtr     <= addrDec;
                    outRemain <= '0;
                    doBitQ    <= 1'b0;
                  end
                  2'b01: begin
                    progAddrQ <= addrDec;
                    pendOp    <= PROG_WRITE;
                    bitCnt    <= '0;
                    dataShift <= '0;
                    if (welQ) state <= ST_DATA;
                  end
                  2'b11: begin
                    if (welQ) begin
                      strbQ     <= '{progStart: 1'b1, op: PROG_ERASE, wide: wideQ};
                      progAddrQ <= addrDec;
                    end
                  end
                  default: begin
                    unique case (sub)
                      2'b11: welQ <= 1'b1;
                      2'b00: welQ <= 1'b0;
                      2'b10: if (welQ) strbQ <= '{progStart: 1'b1, op: PROG_CLEAR, wide: wideQ};
                      default: begin
                        pendOp    <= PROG_FILL;
                        bitCnt    <= '0;
                        dataShift <= '0;
                        if (welQ) state <= ST_DATA;
                      end
                    endcase
                  end
                endcase
              end
            end

            ST_DATA: begin
              dataShift <= dataNext[14:0];
              bitCnt    <= bitNext;
              if (bitNext == wordLen) begin
                state     <= ST_SKIP;
                strbQ     <= '{progStart: 1'b1, op: pendOp, wide: wideQ};
                progDataQ <= dataNext;
              end
            end

            ST_READ: begin
              if (outRemain == '0) begin
                doBitQ    <= loadWord[15];
                outShift  <= {loadWord[14:0], 1'b0};
                outRemain <= wideQ ? 5'd15 : 5'd7;
                rdPtr     <= (rdPtr + ADDR_W8'(1)) & ptrMask;
              end else begin
                doBitQ    <= outShift[15];
                outShift  <= {outShift[14:0], 1'b0};
                outRemain <= outRemain - 5'd1;
              end
            end

            default: ;
          endcase
        end
      end
    end
  end

  assign strb     = strbQ;
  assign progAddr = progAddrQ;
  assign progData = progDataQ;
  assign rdAddr   = rdPtr;
  assign rdWide   = wideQ;
  assign doOut    = statusMode ? ~busy : doBitQ;
  assign doOe     = csS && (statusMode || (state == ST_READ));

  // R5: programming is only ever launched with the enable latch set
  assert_prog_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    strbQ.progStart |-> welQ);

  // R9: a status report only appears after a programming cycle was armed
  assert_status_needs_arm_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusMode) |-> $past(statusArm));

endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
  import seeprom_pkg::*;
#(
  parameter int ADDR_W8     = 11,
  parameter int PROG_CYCLES = 500000,
  parameter int CS_LOW_MIN  = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  input  logic orgWide,
  output logic doOut,
  output logic doOe
);

  logic [2:0]         pinSync;
  progStrobe_t        strb;
  logic [ADDR_W8-1:0] progAddr, rdAddr;
  logic [15:0]        progData, rdWord;
  logic               rdWide, busy;

  seeprom_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({csIn, skIn, diIn}),
    .syncOut (pinSync)
  );

  seeprom_ctrl #(.ADDR_W8(ADDR_W8), .CS_LOW_MIN(CS_LOW_MIN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csS      (pinSync[2]),
    .skS      (pinSync[1]),
    .diS      (pinSync[0]),
    .orgWide  (orgWide),
    .busy     (busy),
    .rdWord   (rdWord),
    .strb     (strb),
    .progAddr (progAddr),
    .progData (progData),
    .rdAddr   (rdAddr),
    .rdWide   (rdWide),
    .doOut    (doOut),
    .doOe     (doOe)
  );

  seeprom_store #(.ADDR_W8(ADDR_W8), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .progAddr (progAddr),
    .progData (progData),
    .rdAddr   (rdAddr),
    .rdWide   (rdWide),
    .rdWord   (rdWord),
    .busy     (busy)
  );

  // R13: a select held low through the synchroniser leaves the output undriven
  assert_oe_off_cs_low_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!csIn && $past(!csIn) && $past(!csIn, 2)) |-> !doOe);

endmodule

// File: tb/seeprom_slave_tb.sv
module seeprom_slave_tb;

  localparam int AW8   = 5;
  localparam int AW16  = AW8 - 1;
  localparam int DEPTH = 1 << AW8;
  localparam int PROG  = 300;
  localparam int CSMIN = 4;

  logic clk = 1'b0;
  logic rstN, csIn, skIn, diIn, orgWide;
  logic doOut, doOe;
  logic [7:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  seeprom_slave #(.ADDR_W8(AW8), .PROG_CYCLES(PROG), .CS_LOW_MIN(CSMIN)) u_dut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .orgWide(orgWide), .doOut(doOut), .doOe(doOe)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input int a, input bit wide);
    if (wide) return {model[(2*a) % DEPTH], model[(2*a+1) % DEPTH]};
    return {8'h00, model[a % DEPTH]};
  endfunction

  task automatic bitOut(input logic d, output logic s);
    diIn = d;
    repeat (4) @(negedge clk);
    s = doOut;
    skIn = 1'b1;
    repeat (4) @(negedge clk);
    skIn = 1'b0;
  endtask

  task automatic csOn();
    @(negedge clk);
    csIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic csOff();
    @(negedge clk);
    csIn = 1'b0;
    diIn = 1'b0;
    repeat (CSMIN + 6) @(negedge clk);
  endtask

  task automatic sendHdr(input logic [1:0] op, input int addr, input bit wide);
    logic s;
    bitOut(1'b1, s);
    bitOut(op[1], s);
    bitOut(op[0], s);
    for (int i = (wide ? AW16 : AW8) - 1; i >= 0; i--) bitOut(1'((addr >> i) & 1), s);
  endtask

  task automatic sendData(input int val, input bit wide);
    logic s;
    for (int i = (wide ? 15 : 7); i >= 0; i--) bitOut(1'((val >> i) & 1), s);
  endtask

  function automatic int subAddr(input int sub, input bit wide);
    return sub << ((wide ? AW16 : AW8) - 2);
  endfunction

  task automatic statusPoll(input string tag);
    int n;
    repeat (6) @(negedge clk);
    check(doOe === 1'b1 && doOut === 1'b0, {tag, " busy"}, {14'd0, doOe, doOut}, 16'h0002);
    n = 0;
    while (doOut !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(doOe === 1'b1 && doOut === 1'b1, {tag, " ready"}, {14'd0, doOe, doOut}, 16'h0003);
  endtask

  task automatic progWait(input string tag);
    csOff();
    csOn();
    statusPoll(tag);
    csOff();
  endtask

  task automatic setModel(input int a, input int val, input bit wide);
    if (wide) begin
      model[(2*a) % DEPTH]   = 8'((val >> 8) & 8'hFF);
      model[(2*a+1) % DEPTH] = 8'(val & 8'hFF);
    end else begin
      model[a % DEPTH] = 8'(val & 8'hFF);
    end
  endtask

  task automatic doWrite(input int a, input int val, input bit wide, input string tag);
    csOn();
    sendHdr(2'b01, a, wide);
    sendData(val, wide);
    setModel(a, val, wide);
    progWait(tag);
  endtask

  task automatic cmdSub(input int sub, input bit wide);
    csOn();
    sendHdr(2'b00, subAddr(sub, wide), wide);
    csOff();
  endtask

  task automatic doRead(input int start, input int count, input bit wide, input int lead, input string tag);
    logic s;
    logic [15:0] w;
    int words;
    words = wide ? DEPTH / 2 : DEPTH;
    csOn();
    for (int i = 0; i < lead; i++) bitOut(1'b0, s);
    sendHdr(2'b10, start, wide);
    bitOut(1'b0, s);
    check(s === 1'b0 && doOe === 1'b1, {"R3 dummy ", tag}, {15'd0, s}, 16'h0000);
    for (int k = 0; k < count; k++) begin
      w = '0;
      for (int b = 0; b < (wide ? 16 : 8); b++) begin
        bitOut(1'b0, s);
        w = {w[14:0], s};
      end
      check(w === expWord((start + k) % words, wide), {tag, " word"}, w, expWord((start + k) % words, wide));
    end
    csOff();
    check(doOe === 1'b0, "R13 oe after deselect", {15'd0, doOe}, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; csIn = 1'b0; skIn = 1'b0; diIn = 1'b0; orgWide = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(doOe === 1'b0, "R13 reset oe", {15'd0, doOe}, 16'h0000);
    csOn();
    check(doOe === 1'b0, "R13 idle selected oe", {15'd0, doOe}, 16'h0000);
    csOff();

    // R5 enable, R7 bulk erase, R4 sequential read with wrap
    cmdSub(3, 1'b0);
    csOn();
    sendHdr(2'b00, subAddr(2, 1'b0), 1'b0);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    progWait("R7 bulk erase");
    doRead(0, DEPTH + 1, 1'b0, 0, "R7 R4 erased array");

    // R5 programming locked out
    cmdSub(0, 1'b0);
    csOn();
    sendHdr(2'b01, 7, 1'b0);
    sendData(8'h12, 1'b0);
    csOff();
    csOn();
    repeat (6) @(negedge clk);
    check(doOe === 1'b0, "R5 no busy when disabled", {15'd0, doOe}, 16'h0000);
    csOff();
    doRead(7, 1, 1'b0, 0, "R5 locked write");

    // R6 write every byte, R4 read all with wrap
    cmdSub(3, 1'b0);
    for (int a = 0; a < DEPTH; a++) doWrite(a, (a * 29 + 3) & 8'hFF, 1'b0, "R6 R9 write");
    doRead(0, DEPTH + 1, 1'b0, 0, "R6 R4 byte sweep");

    // R1 leading zeros before the start bit
    doRead(9, 2, 1'b0, 2, "R1 leading zeros");

    // R7 single erase
    csOn();
    sendHdr(2'b11, 4, 1'b0);
    model[4] = 8'hFF;
    progWait("R7 erase");
    doRead(3, 3, 1'b0, 0, "R7 erase one");

    // R11 instruction while busy is ignored
    csOn();
    sendHdr(2'b01, 1, 1'b0);
    sendData(8'hA5, 1'b0);
    model[1] = 8'hA5;
    csOff();
    csOn();
    sendHdr(2'b01, 2, 1'b0);
    sendData(8'h3C, 1'b0);
    check(doOe === 1'b1 && doOut === 1'b0, "R11 R9 still busy", {14'd0, doOe, doOut}, 16'h0002);
    statusPoll("R11 status");
    csOff();
    doRead(1, 2, 1'b0, 0, "R11 ignored write");

    // R10 select rises after the cycle ended
    csOn();
    sendHdr(2'b01, 5, 1'b0);
    sendData(8'h77, 1'b0);
    model[5] = 8'h77;
    csOff();
    repeat (PROG + 50) @(negedge clk);
    csOn();
    repeat (6) @(negedge clk);
    check(doOe === 1'b0, "R10 late select", {15'd0, doOe}, 16'h0000);
    csOff();

    // R9 short deselect gives no status, a full one does
    csOn();
    sendHdr(2'b01, 6, 1'b0);
    sendData(8'h66, 1'b0);
    model[6] = 8'h66;
    @(negedge clk);
    csIn = 1'b0;
    repeat (2) @(negedge clk);
    csIn = 1'b1;
    repeat (8) @(negedge clk);
    check(doOe === 1'b0, "R9 short low pulse", {15'd0, doOe}, 16'h0000);
    csOff();
    csOn();
    statusPoll("R9 after full low");
    csOff();
    doRead(5, 2, 1'b0, 0, "R9 R10 written");

    // R12 abandoned write
    csOn();
    sendHdr(2'b01, 8, 1'b0);
    begin
      logic s;
      bitOut(1'b0, s); bitOut(1'b1, s); bitOut(1'b0, s);
    end
    csOff();
    csOn();
    repeat (6) @(negedge clk);
    check(doOe === 1'b0, "R12 no status after abort", {15'd0, doOe}, 16'h0000);
    csOff();
    doRead(8, 1, 1'b0, 0, "R12 aborted write");

    // R5 erase and fill refused while disabled
    cmdSub(0, 1'b0);
    csOn();
    sendHdr(2'b11, 8, 1'b0);
    csOff();
    csOn();
    sendHdr(2'b00, subAddr(1, 1'b0), 1'b0);
    sendData(8'h00, 1'b0);
    csOff();
    doRead(0, DEPTH, 1'b0, 0, "R5 locked erase and fill");

    // R2 word organisation
    orgWide = 1'b1;
    cmdSub(3, 1'b1);
    for (int w = 0; w < DEPTH / 2; w++) doWrite(w, (w * 16'h1357 + 16'h0A0B) & 16'hFFFF, 1'b1, "R2 R6 word write");
    doRead(0, DEPTH / 2 + 1, 1'b1, 0, "R2 R4 word sweep");
    orgWide = 1'b0;
    doRead(0, 4, 1'b0, 0, "R2 byte placement");

    // R8 fill
    csOn();
    sendHdr(2'b00, subAddr(1, 1'b0), 1'b0);
    sendData(8'h5A, 1'b0);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h5A;
    progWait("R8 fill");
    doRead(0, DEPTH, 1'b0, 0, "R8 filled array");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule